// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit side of a descriptor-driven Ethernet DMA engine. Software places four-word descriptors in memory: status, control, buffer address and a spare word, 16 bytes apart. It hands each descriptor to the engine by setting the ownership bit, then writes the poll register. On a poll the engine reads the descriptor at its current pointer. If it owns the descriptor, it streams the buffer bytes to the MAC over a valid/ready byte interface, writes back a completion status that gives ownership back, and moves on to the next descriptor. It keeps going until it meets a descriptor it does not own, and then waits for the next poll.

A descriptor marked as a setup frame is never sent on the wire. Its 48-word buffer instead loads a sixteen-entry exact-match table of 48-bit station addresses. The receive side can query that table through a lookup port. The host registers hold the ring base, a run bit and the poll trigger. A three-bit process-state code shows what the engine is doing.

Top module: `txdesc_engine`

## Requirements
- R1: After reset, tx_pstate reads 0, mem_req and tx_valid are low, and flt_hit is low for every lookup address, including all ones.
- R2: Host register addresses are 0 for poll, 1 for ring base and 2 for mode, where bit 13 is run. Setting run moves the engine to suspended (code 6) with its pointer at the ring base, and no memory access happens until a poll. A poll written while stopped is ignored.
- R3: A poll while suspended reads the status word at the pointer. If bit 31 (ownership) is clear, the engine returns to suspended after that one read and writes nothing.
- R4: For an owned descriptor, the engine reads control at pointer+4 and the buffer address at pointer+8. It then sends exactly control[10:0] bytes. Byte k of the buffer is bits 8*(k%4)+7 down to 8*(k%4) of word k/4, and tx_last is high only with the final byte.
- R5: The completion write goes to the status word. It is 0x00000000 on success. It is 0x00008000 (bit 15, error) if tx_err was high during any accepted byte, or if the length is zero, in which case no byte is sent.
- R6: After completion, the engine fetches the next descriptor at pointer+16. If control bit 25 (end of ring) was set, it fetches at the ring base instead. It keeps fetching until it finds a descriptor it does not own.
- R7: A descriptor with control bit 27 (setup) reads 48 buffer words, sends no byte, ignores the length, and writes back status 0x7FFFFFFF.
- R8: In a setup buffer, words 3n, 3n+1 and 3n+2 supply bits 15:0, 31:16 and 47:32 of entry n from their low halves; the upper halves are ignored. flt_hit is high when flt_addr equals any entry, so an all-ones entry matches broadcast. It stays low until a setup load has completed.
- R9: Clearing run while suspended moves the engine to stopped (code 0), and a later poll causes no memory access. A descriptor already in progress is completed first.
- R10: tx_pstate reads 1 while fetching a descriptor, 3 while moving frame data, 5 while loading a setup frame, 7 while writing status, 6 when suspended and 0 when stopped.
- R11: A memory request that has not been acknowledged keeps its address and direction. An offered byte that has not been accepted keeps its data and tx_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte offered to MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | MAC accepts byte |
| tx_err | input | 1 | MAC reports failure with accepted byte |
| flt_addr | input | 48 | Address to look up |
| flt_hit | output | 1 | Address matches a table entry |
| tx_pstate | output | 3 | Process-state code |

## Verification
The assertions check, on every cycle, the rules that hold at any instant. Requests and offered bytes must stay stable while stalled. A status write must never leave the ownership bit set. A setup load and the suspended and stopped states must never reach the wire or memory in the wrong way. A hit must never appear before the table is loaded. The directed scenarios are the only way to show the rest: the byte order, the exact status values, the wrap to the ring base, the contents of the filter table, and the fact that a poll or a host-owned descriptor has no effect. These are sequences across many cycles, checked against memory and the captured byte stream.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int AW          = 32;
    localparam int DW          = 32;
    localparam int LEN_W       = 11;
    localparam int N_ENT       = 16;
    localparam int ENT_W       = $clog2(N_ENT);
    localparam int DESC_STRIDE = 16;
    localparam int WORD_BYTES  = DW / 8;

    localparam int CTL_TER = 25;
    localparam int CTL_SET = 27;
    localparam int ST_OWN  = 31;
    localparam int ST_ERR  = 15;
    localparam logic [DW-1:0] SETUP_DONE = 32'h7FFF_FFFF;

    localparam logic [1:0] RA_POLL = 2'd0;
    localparam logic [1:0] RA_BASE = 2'd1;
    localparam logic [1:0] RA_MODE = 2'd2;
    localparam int MODE_RUN = 13;

    localparam logic [2:0] PS_STOP  = 3'd0;
    localparam logic [2:0] PS_FETCH = 3'd1;
    localparam logic [2:0] PS_XFER  = 3'd3;
    localparam logic [2:0] PS_SETUP = 3'd5;
    localparam logic [2:0] PS_SUSP  = 3'd6;
    localparam logic [2:0] PS_CLOSE = 3'd7;

    typedef enum logic [3:0] {
        S_STOP, S_SUSP, S_RD_ST, S_RD_CTL, S_RD_BUF,
        S_RD_DAT, S_SEND, S_SETUP, S_WB
    } eng_state_e;

    typedef struct packed {
        logic             ter;
        logic             setup;
        logic [LEN_W-1:0] len;
    } ctl_t;

    function automatic logic [2:0] pstate_of(eng_state_e s);
        case (s)
            S_STOP:                      return PS_STOP;
            S_SUSP:                      return PS_SUSP;
            S_RD_ST, S_RD_CTL, S_RD_BUF: return PS_FETCH;
            S_RD_DAT, S_SEND:            return PS_XFER;
            S_SETUP:                     return PS_SETUP;
            default:                     return PS_CLOSE;
        endcase
    endfunction
endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic          run,
    output logic [AW-1:0] base,
    output logic          poll
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            base <= '0;
            poll <= 1'b0;
        end else begin
            poll <= wr && (addr == RA_POLL);
            if (wr && addr == RA_BASE) base <= wdata[AW-1:0];
            if (wr && addr == RA_MODE) run  <= wdata[MODE_RUN];
        end
    end

    p_poll_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        poll |=> !poll || $past(wr && addr == RA_POLL));
endmodule

// File: rtl/txd_filter.sv
module txd_filter
    import txd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [ENT_W-1:0] ent,
    input  logic [1:0]       part,
    input  logic [15:0]      wdata,
    input  logic [47:0]      lk_addr,
    output logic             lk_hit
);
    logic [47:0]      tbl [N_ENT];
    logic [N_ENT-1:0] match;
    logic             loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded <= 1'b0;
            for (int i = 0; i < N_ENT; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[ent][{part, 4'b0000} +: 16] <= wdata;
            if (ent == ENT_W'(N_ENT - 1) && part == 2'd2) loaded <= 1'b1;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = (tbl[g] == lk_addr);
    end

    assign lk_hit = loaded && (|match);

    p_hit_needs_load_r8: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> loaded);
    p_part_range_r8: assert property (@(posedge clk) disable iff (rst)
        we |-> part != 2'd3);
endmodule

// File: rtl/txd_fsm.sv
module txd_fsm
    import txd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [AW-1:0]    base,
    input  logic             poll,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    input  logic             tx_err,
    output logic             flt_we,
    output logic [ENT_W-1:0] flt_ent,
    output logic [1:0]       flt_part,
    output logic [15:0]      flt_data,
    output logic [2:0]       pstate
);
    eng_state_e       st;
    ctl_t             ctl;
    logic [AW-1:0]    cur, bufp;
    logic [DW-1:0]    wbuf;
    logic [1:0]       bsel;
    logic [LEN_W-1:0] rem;
    logic             err;
    logic [ENT_W-1:0] ent;
    logic [1:0]       part;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_STOP; ctl <= '0; cur <= '0; bufp <= '0; wbuf <= '0;
            bsel <= '0; rem <= '0; err <= 1'b0; ent <= '0; part <= '0;
        end else begin
            case (st)
                S_STOP: if (run) begin cur <= base; st <= S_SUSP; end
                S_SUSP: begin
                    if (!run)      st <= S_STOP;
                    else if (poll) st <= S_RD_ST;
                end
                S_RD_ST: if (mem_ack)
                    st <= mem_rdata[ST_OWN] ? S_RD_CTL : (run ? S_SUSP : S_STOP);
                S_RD_CTL: if (mem_ack) begin
                    ctl <= '{ter: mem_rdata[CTL_TER], setup: mem_rdata[CTL_SET],
                             len: mem_rdata[LEN_W-1:0]};
                    st  <= S_RD_BUF;
                end
                S_RD_BUF: if (mem_ack) begin
                    bufp <= mem_rdata;
                    rem  <= ctl.len;
                    err  <= 1'b0;
                    ent  <= '0;
                    part <= '0;
                    if (ctl.setup)          st <= S_SETUP;
                    else if (ctl.len == '0) begin err <= 1'b1; st <= S_WB; end
                    else                    st <= S_RD_DAT;
                end
                S_RD_DAT: if (mem_ack) begin
                    wbuf <= mem_rdata;
                    bufp <= bufp + AW'(WORD_BYTES);
                    bsel <= '0;
                    st   <= S_SEND;
                end
                S_SEND: if (tx_ready) begin
                    err  <= err | tx_err;
                    rem  <= rem - 1'b1;
                    bsel <= bsel + 1'b1;
                    if (rem == LEN_W'(1))  st <= S_WB;
                    else if (bsel == 2'd3) st <= S_RD_DAT;
                end
                S_SETUP: if (mem_ack) begin
                    bufp <= bufp + AW'(WORD_BYTES);
                    if (part == 2'd2) begin
                        part <= '0;
                        ent  <= ent + 1'b1;
                        if (ent == ENT_W'(N_ENT - 1)) st <= S_WB;
                    end else begin
                        part <= part + 1'b1;
                    end
                end
                S_WB: if (mem_ack) begin
                    cur <= ctl.ter ? base : cur + AW'(DESC_STRIDE);
                    st  <= run ? S_RD_ST : S_STOP;
                end
                default: st <= S_STOP;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        case (st)
            S_RD_ST:           mem_addr = cur;
            S_RD_CTL:          mem_addr = cur + AW'(4);
            S_RD_BUF:          mem_addr = cur + AW'(8);
            S_RD_DAT, S_SETUP: mem_addr = bufp;
            S_WB: begin
                mem_we    = 1'b1;
                mem_wdata = ctl.setup ? SETUP_DONE : (DW'(err) << ST_ERR);
            end
            default:           mem_req = 1'b0;
        endcase
    end

    assign tx_valid = (st == S_SEND);
    assign tx_data  = wbuf[{bsel, 3'b000} +: 8];
    assign tx_last  = tx_valid && (rem == LEN_W'(1));
    assign flt_we   = (st == S_SETUP) && mem_ack;
    assign flt_ent  = ent;
    assign flt_part = part;
    assign flt_data = mem_rdata[15:0];
    assign pstate   = pstate_of(st);

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    p_byte_hold_r11: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    p_own_release_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[ST_OWN]);
    p_setup_silent_r7: assert property (@(posedge clk) disable iff (rst)
        pstate == PS_SETUP |-> !tx_valid);
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (pstate == PS_STOP || pstate == PS_SUSP) |-> !mem_req && !tx_valid);
    p_stop_holds_r9: assert property (@(posedge clk) disable iff (rst)
        pstate == PS_STOP && !run |=> pstate == PS_STOP);
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
    import txd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        tx_err,
    input  logic [47:0] flt_addr,
    output logic        flt_hit,
    output logic [2:0]  tx_pstate
);
    logic             run, poll;
    logic [AW-1:0]    base;
    logic             f_we;
    logic [ENT_W-1:0] f_ent;
    logic [1:0]       f_part;
    logic [15:0]      f_data;

    txd_regs u_regs (
        .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
        .run(run), .base(base), .poll(poll)
    );

    txd_fsm u_fsm (
        .clk(clk), .rst(rst), .run(run), .base(base), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_err(tx_err),
        .flt_we(f_we), .flt_ent(f_ent), .flt_part(f_part), .flt_data(f_data),
        .pstate(tx_pstate)
    );

    txd_filter u_flt (
        .clk(clk), .rst(rst), .we(f_we), .ent(f_ent), .part(f_part),
        .wdata(f_data), .lk_addr(flt_addr), .lk_hit(flt_hit)
    );
endmodule

// File: tb/sim_txdesc_engine.sv
`timescale 1ns/1ps
module sim_txdesc_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready, tx_err;
    logic [7:0]  tx_data;
    logic [47:0] flt_addr = '0;
    logic        flt_hit;
    logic [2:0]  tx_pstate;

    always #5 clk = ~clk;

    txdesc_engine u0 (.*);

    int tests = 0, fails = 0;

    // memory model, host-side write port and activity counters
    logic [31:0] mem [256];
    logic        hw_en = 1'b0;
    logic [7:0]  hw_idx = '0;
    logic [31:0] hw_val = '0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd = '0;
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
    end
    always @(posedge clk) begin
        if (hw_en) mem[hw_idx] <= hw_val;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
                rd_cnt <= rd_cnt + 1;
                last_rd <= mem_addr;
            end
        end else mem_ack <= 1'b0;
    end

    // MAC sink
    logic [7:0] cap [64];
    logic       cap_last [64];
    int         ncap = 0, cyc = 0, err_idx = -1;
    logic [7:0] seen = '0;
    logic       seen_clr = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (seen_clr) seen <= '0; else seen[tx_pstate] <= 1'b1;
        if (tx_valid && tx_ready && ncap < 64) begin
            cap[ncap] <= tx_data;
            cap_last[ncap] <= tx_last;
            ncap <= ncap + 1;
        end
    end
    always @(negedge clk) begin
        tx_ready <= (cyc % 3) != 1;
        tx_err   <= (ncap == err_idx);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic mem_put(input logic [31:0] byte_addr, input logic [31:0] d);
        @(negedge clk); hw_en = 1'b1; hw_idx = byte_addr[9:2]; hw_val = d;
        @(negedge clk); hw_en = 1'b0;
    endtask

    task automatic desc_put(input logic [31:0] a, input logic [31:0] st,
                            input logic [31:0] ctl, input logic [31:0] bp);
        mem_put(a, st); mem_put(a + 4, ctl); mem_put(a + 8, bp);
    endtask

    task automatic poll_and_wait();
        host_write(2'd0, 32'h0);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 2000 && tx_pstate != 3'd6; i++) @(negedge clk);
    endtask

    function automatic logic [47:0] fa(input int e);
        return (e == 5) ? 48'hFFFF_FFFF_FFFF
                        : {8'hA0 + 8'(e), 8'h55, 8'h12, 8'(e * 7), 8'h3C, 8'h01 + 8'(e)};
    endfunction

    function automatic logic [7:0] buf_byte(input logic [31:0] bp, input int k);
        logic [31:0] w;
        w = mem[(bp[9:2] + 8'(k / 4))];
        return w[8 * (k % 4) +: 8];
    endfunction

    task automatic t_reset();
        flt_addr = 48'hFFFF_FFFF_FFFF;
        @(negedge clk);
        chk("R1 pstate", 32'(tx_pstate), 32'd0);
        chk("R1 req/valid", {30'b0, mem_req, tx_valid}, 32'd0);
        chk("R1 no hit before load", 32'(flt_hit), 32'd0);
    endtask

    task automatic t_poll_stopped();
        int r0 = rd_cnt;
        host_write(2'd0, 32'h0);
        repeat (10) @(negedge clk);
        chk("R2 poll while stopped reads", 32'(rd_cnt - r0), 32'd0);
        chk("R2 still stopped", 32'(tx_pstate), 32'd0);
    endtask

    task automatic t_start();
        int r0 = rd_cnt;
        host_write(2'd1, 32'h40);
        host_write(2'd2, 32'h2000);
        repeat (5) @(negedge clk);
        chk("R2 suspended after run", 32'(tx_pstate), 32'd6);
        chk("R2 no access before poll", 32'(rd_cnt - r0), 32'd0);
    endtask

    task automatic t_not_owned();
        int r0 = rd_cnt, w0 = wr_cnt;
        poll_and_wait();
        chk("R3 single read", 32'(rd_cnt - r0), 32'd1);
        chk("R3 no write", 32'(wr_cnt - w0), 32'd0);
        chk("R3 read at pointer", last_rd, 32'h40);
        chk("R3 suspended", 32'(tx_pstate), 32'd6);
    endtask

    task automatic t_frame();
        int n0 = ncap, bad = 0, lasts = 0;
        mem_put(32'h100, 32'h4433_2211); mem_put(32'h104, 32'h8877_6655);
        desc_put(32'h40, 32'h8000_0000, 32'h6000_0007, 32'h100);
        @(negedge clk); seen_clr = 1'b1; @(negedge clk); seen_clr = 1'b0;
        poll_and_wait();
        chk("R4 byte count", 32'(ncap - n0), 32'd7);
        for (int k = 0; k < 7; k++) begin
            if (cap[n0 + k] !== buf_byte(32'h100, k)) bad++;
            if (cap_last[n0 + k]) lasts++;
        end
        chk("R4 byte order", 32'(bad), 32'd0);
        chk("R4 last flag count", 32'(lasts), 32'd1);
        chk("R4 last on final", 32'(cap_last[n0 + 6]), 32'd1);
        chk("R5 success status", mem[16], 32'h0);
        chk("R6 next at +16", last_rd, 32'h50);
        chk("R10 states fetch/xfer/close", {29'b0, seen[1], seen[3], seen[7]}, 32'h7);
    endtask

    task automatic t_err_frame();
        int n0 = ncap;
        mem_put(32'h120, 32'hCAFE_F00D); mem_put(32'h124, 32'h0000_00EE);
        desc_put(32'h50, 32'h8000_0000, 32'h6000_0005, 32'h120);
        err_idx = n0 + 2;
        poll_and_wait();
        err_idx = -1;
        chk("R5 bytes sent on error", 32'(ncap - n0), 32'd5);
        chk("R5 error status", mem[20], 32'h0000_8000);
    endtask

    task automatic t_setup();
        int n0 = ncap;
        for (int w = 0; w < 48; w++) begin
            logic [47:0] a = fa(w / 3);
            mem_put(32'h200 + 32'(4 * w), {16'hDEAD, a[16 * (w % 3) +: 16]});
        end
        desc_put(32'h60, 32'h8000_0000, 32'h0A00_0040, 32'h200);
        @(negedge clk); seen_clr = 1'b1; @(negedge clk); seen_clr = 1'b0;
        poll_and_wait();
        chk("R7 nothing sent", 32'(ncap - n0), 32'd0);
        chk("R7 setup status", mem[24], 32'h7FFF_FFFF);
        chk("R10 setup state seen", 32'(seen[5]), 32'd1);
        chk("R6 wrap to base", last_rd, 32'h40);
        flt_addr = fa(3);                @(negedge clk); chk("R8 hit entry 3", 32'(flt_hit), 32'd1);
        flt_addr = fa(15);               @(negedge clk); chk("R8 hit entry 15", 32'(flt_hit), 32'd1);
        flt_addr = fa(3) ^ 48'h1;        @(negedge clk); chk("R8 miss", 32'(flt_hit), 32'd0);
        flt_addr = {fa(0)[47:16], 16'hDEAD}; @(negedge clk); chk("R8 upper half ignored", 32'(flt_hit), 32'd0);
        flt_addr = 48'hFFFF_FFFF_FFFF;   @(negedge clk); chk("R8 broadcast", 32'(flt_hit), 32'd1);
    endtask

    task automatic t_zero_len();
        int n0 = ncap;
        desc_put(32'h40, 32'h8000_0000, 32'h6000_0000, 32'h100);
        poll_and_wait();
        chk("R5 zero length sends none", 32'(ncap - n0), 32'd0);
        chk("R5 zero length error", mem[16], 32'h0000_8000);
    endtask

    task automatic t_stop();
        int r0;
        host_write(2'd2, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 stopped", 32'(tx_pstate), 32'd0);
        r0 = rd_cnt;
        host_write(2'd0, 32'h0);
        repeat (10) @(negedge clk);
        chk("R9 poll ignored when stopped", 32'(rd_cnt - r0), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_poll_stopped();
        t_start();
        t_not_owned();
        t_frame();
        t_err_frame();
        t_setup();
        t_zero_len();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule